// File: doc/BRIEF.md
# Exception Entry Vector Sequencer

This block works out everything that changes in the architectural control state when a processor takes an exception. The pipeline presents the kind of event, the faulting PC, whether that PC sits in a branch delay slot, a TLB no-match flag, a coprocessor unit number, the exception base, and the current status, cause, exception-PC, error-PC, debug-PC, debug-flag and debug-mode values. When the take strobe is high, all of the updated values, including the new fetch PC, are registered together on one clock edge. The registered result appears at the outputs one cycle later, along with a one-cycle `taken_o` pulse.

Events fall into three families. General exceptions save a return address to the exception PC, unless the exception level bit is already set, and then vector through either the boot base or the programmed base. Reset-like events save the return address to the error PC and jump to the boot vector. Debug-class events save the return address to the debug PC and jump to the debug vector. In every family, an event raised in a delay slot returns to the branch at PC−4. The only exception to this is single-step, which always returns to the PC itself.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every output is zero.
- R2: For a general kind, the outputs change as follows. Status bit 0 (exception level) is set. Status bits 6:5 (privilege mode) are cleared to 00, which means kernel. The exception code goes to cause bits 6:2. Every other status and cause bit is copied from the inputs, except cause bit 31 (delay flag) and, for a coprocessor fault, cause bits 29:28. The general kinds and their codes are: 0 interrupt→0, 1 TLB modify→1, 2 TLB load→2, 3 TLB store→3, 4 address-error load→4, 5 address-error store→5, 6 syscall→8, 7 break→9, 8 reserved instruction→10, 9 coprocessor unusable→11, 10 overflow→12.
- R3: If input status bit 0 is clear when a general kind is taken, the exception PC is set as follows. In a delay slot it becomes PC−4 and cause bit 31 is set. Otherwise it becomes PC and cause bit 31 is cleared. If status bit 0 is already set, both the exception PC and cause bit 31 are passed through unchanged.
- R4: For general kinds, the new PC is a base plus an offset. The base is 0xBFC00200 when status bit 2 (boot vectors) is set. Otherwise it is the exception base input with ten low zero bits appended. The offset is 0x180 unless R5 or R6 selects another one.
- R5: A TLB load or store (kinds 2, 3) uses offset 0x000 only when the no-match flag is high and status bit 0 is clear. In every other case it uses 0x180.
- R6: An interrupt (kind 0) taken outside debug mode uses offset 0x200 when cause bit 23 is set, and 0x180 when it is clear.
- R7: For coprocessor unusable (kind 9), the unit number is written to cause bits 29:28.
- R8: Kinds 11 (reset), 12 (soft reset) and 13 (NMI) have the following effects:
  - The return address (PC−4 in a delay slot, else PC) goes to the error PC.
  - Status bits 1 (error level) and 2 are set, and bits 6:5 are cleared.
  - If status bit 0 was clear, cause bit 31 is cleared.
  - The exception PC is unchanged.
  - The new PC is 0xBFC00000.
  - Soft reset also sets status bit 3, and NMI also sets status bit 4.
- R9: Kinds 14 to 19 are debug events. In order they are single-step, debug interrupt, instruction break, breakpoint, data-load break and data-store break. Each one sets debug-flag bit (kind−14) and sets the debug-mode output. It also clears status bits 6:5, clears cause bit 31 if status bit 0 was clear, and sets the new PC to 0xBFC00480. The debug PC receives the return address. Single-step never rewinds, so its debug PC is always the PC.
- R10: An interrupt (kind 0) with `dm_i` high is taken as a debug interrupt (kind 15) instead.
- R11: Without the take strobe, or for a kind of 20 or above, all outputs hold their previous values and `taken_o` is low. A valid take raises `taken_o` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Take-exception strobe |
| kind_i | input | 5 | Event kind code (see R2, R8, R9) |
| pc_i | input | AW | PC of the faulting instruction |
| delay_slot_i | input | 1 | Faulting instruction is in a delay slot |
| tlb_nomatch_i | input | 1 | TLB fault had no matching entry |
| cop_unit_i | input | 2 | Coprocessor unit number |
| ebase_i | input | AW-10 | Exception base, upper bits |
| status_i | input | 8 | Current status word |
| cause_i | input | 32 | Current cause word |
| epc_i | input | AW | Current exception PC |
| errorepc_i | input | AW | Current error PC |
| depc_i | input | AW | Current debug PC |
| debug_i | input | 6 | Current debug event flags |
| dm_i | input | 1 | Currently in debug mode |
| taken_o | output | 1 | Pulse: an update was registered |
| pc_o | output | AW | New fetch PC |
| status_o | output | 8 | Updated status word |
| cause_o | output | 32 | Updated cause word |
| epc_o | output | AW | Updated exception PC |
| errorepc_o | output | AW | Updated error PC |
| depc_o | output | AW | Updated debug PC |
| debug_o | output | 6 | Updated debug event flags |
| dm_o | output | 1 | Updated debug mode |

## Verification
The bench targets delay-slot entries with the exception level both clear and already set. A design that overwrote the exception PC at a nested level would lose the first return address, and one that ignored the slot flag would resume after the branch. It drives TLB misses with and without the no-match flag and with the level bit set, since a wrong refill choice sends nested misses to offset 0 and loops. Single-step in a delay slot, interrupts in debug mode, interrupts with the vector-select bit set, and out-of-range kinds are all forced as well. Each of these would otherwise show up as a wrong debug PC, a general entry where a debug entry belongs, a wrong vector, or state that changes when it should hold.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_ALIGN = 10;
    localparam int CAUSE_W   = 32;
    localparam int STAT_W    = 8;
    localparam int DBG_W     = 6;
    localparam int CODE_W    = 5;

    // status word bit positions
    localparam int ST_EXL = 0;
    localparam int ST_ERL = 1;
    localparam int ST_BEV = 2;
    localparam int ST_SR  = 3;
    localparam int ST_NMI = 4;
    localparam int ST_KSU = 5;   // two bits, 6:5

    // cause word bit positions
    localparam int CA_CODE = 2;  // five bits, 6:2
    localparam int CA_IV   = 23;
    localparam int CA_CE   = 28; // two bits, 29:28
    localparam int CA_BD   = 31;

    localparam logic [VEC_ALIGN-1:0] OFF_REFILL  = 10'h000;
    localparam logic [VEC_ALIGN-1:0] OFF_GENERAL = 10'h180;
    localparam logic [VEC_ALIGN-1:0] OFF_IRQ     = 10'h200;

    typedef enum logic [4:0] {
        EX_INT        = 5'd0,
        EX_TLB_MOD    = 5'd1,
        EX_TLB_LOAD   = 5'd2,
        EX_TLB_STORE  = 5'd3,
        EX_ADDR_LOAD  = 5'd4,
        EX_ADDR_STORE = 5'd5,
        EX_SYSCALL    = 5'd6,
        EX_BREAK      = 5'd7,
        EX_RESV_INSN  = 5'd8,
        EX_COP_UNUSE  = 5'd9,
        EX_OVERFLOW   = 5'd10,
        EX_RESET      = 5'd11,
        EX_SOFT_RESET = 5'd12,
        EX_NMI        = 5'd13,
        EX_DBG_STEP   = 5'd14,
        EX_DBG_INT    = 5'd15,
        EX_DBG_IBRK   = 5'd16,
        EX_DBG_BRK    = 5'd17,
        EX_DBG_DLOAD  = 5'd18,
        EX_DBG_DSTORE = 5'd19
    } exc_kind_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_GEN  = 2'd1,
        CLS_ERR  = 2'd2,
        CLS_DBG  = 2'd3
    } exc_class_e;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  logic [4:0]           kind_i,
    input  logic                 dm_i,
    input  logic                 exl_i,
    input  logic                 nomatch_i,
    input  logic                 iv_i,
    output exc_class_e           cls_o,
    output logic [CODE_W-1:0]    code_o,
    output logic [VEC_ALIGN-1:0] off_o,
    output logic [DBG_W-1:0]     dmask_o,
    output logic                 rewind_o,
    output logic                 set_sr_o,
    output logic                 set_nmi_o,
    output logic                 cop_o
);

    always_comb begin
        cls_o     = CLS_NONE;
        code_o    = '0;
        off_o     = OFF_GENERAL;
        dmask_o   = '0;
        rewind_o  = 1'b1;
        set_sr_o  = 1'b0;
        set_nmi_o = 1'b0;
        cop_o     = 1'b0;
        case (kind_i)
            EX_INT: begin
                if (dm_i) begin
                    cls_o      = CLS_DBG;
                    dmask_o[1] = 1'b1;
                end else begin
                    cls_o  = CLS_GEN;
                    code_o = 5'd0;
                    off_o  = iv_i ? OFF_IRQ : OFF_GENERAL;
                end
            end
            EX_TLB_MOD:    begin cls_o = CLS_GEN; code_o = 5'd1; end
            EX_TLB_LOAD, EX_TLB_STORE: begin
                cls_o  = CLS_GEN;
                code_o = (kind_i == EX_TLB_LOAD) ? 5'd2 : 5'd3;
                off_o  = (nomatch_i && !exl_i) ? OFF_REFILL : OFF_GENERAL;
            end
            EX_ADDR_LOAD:  begin cls_o = CLS_GEN; code_o = 5'd4;  end
            EX_ADDR_STORE: begin cls_o = CLS_GEN; code_o = 5'd5;  end
            EX_SYSCALL:    begin cls_o = CLS_GEN; code_o = 5'd8;  end
            EX_BREAK:      begin cls_o = CLS_GEN; code_o = 5'd9;  end
            EX_RESV_INSN:  begin cls_o = CLS_GEN; code_o = 5'd10; end
            EX_COP_UNUSE:  begin cls_o = CLS_GEN; code_o = 5'd11; cop_o = 1'b1; end
            EX_OVERFLOW:   begin cls_o = CLS_GEN; code_o = 5'd12; end
            EX_RESET:      cls_o = CLS_ERR;
            EX_SOFT_RESET: begin cls_o = CLS_ERR; set_sr_o  = 1'b1; end
            EX_NMI:        begin cls_o = CLS_ERR; set_nmi_o = 1'b1; end
            EX_DBG_STEP, EX_DBG_INT, EX_DBG_IBRK,
            EX_DBG_BRK, EX_DBG_DLOAD, EX_DBG_DSTORE: begin
                cls_o    = CLS_DBG;
                dmask_o  = DBG_W'(1) << (kind_i - EX_DBG_STEP);
                rewind_o = (kind_i != EX_DBG_STEP);
            end
            default: cls_o = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter int               AW        = 32,
    parameter logic [AW-1:0]    BOOT_GEN  = 32'hBFC0_0200,
    parameter logic [AW-1:0]    RESET_VEC = 32'hBFC0_0000,
    parameter logic [AW-1:0]    DEBUG_VEC = 32'hBFC0_0480
) (
    input  exc_class_e            cls_i,
    input  logic                  bev_i,
    input  logic [AW-1:VEC_ALIGN] ebase_i,
    input  logic [VEC_ALIGN-1:0]  off_i,
    output logic [AW-1:0]         target_o
);

    logic [AW-1:0] gen_base;

    always_comb begin
        gen_base = bev_i ? BOOT_GEN : {ebase_i, {VEC_ALIGN{1'b0}}};
        case (cls_i)
            CLS_GEN: target_o = gen_base + AW'(off_i);
            CLS_ERR: target_o = RESET_VEC;
            CLS_DBG: target_o = DEBUG_VEC;
            default: target_o = '0;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] BOOT_GEN  = 32'hBFC0_0200,
    parameter logic [AW-1:0] RESET_VEC = 32'hBFC0_0000,
    parameter logic [AW-1:0] DEBUG_VEC = 32'hBFC0_0480
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_i,
    input  logic [4:0]            kind_i,
    input  logic [AW-1:0]         pc_i,
    input  logic                  delay_slot_i,
    input  logic                  tlb_nomatch_i,
    input  logic [1:0]            cop_unit_i,
    input  logic [AW-1:VEC_ALIGN] ebase_i,
    input  logic [STAT_W-1:0]     status_i,
    input  logic [CAUSE_W-1:0]    cause_i,
    input  logic [AW-1:0]         epc_i,
    input  logic [AW-1:0]         errorepc_i,
    input  logic [AW-1:0]         depc_i,
    input  logic [DBG_W-1:0]      debug_i,
    input  logic                  dm_i,
    output logic                  taken_o,
    output logic [AW-1:0]         pc_o,
    output logic [STAT_W-1:0]     status_o,
    output logic [CAUSE_W-1:0]    cause_o,
    output logic [AW-1:0]         epc_o,
    output logic [AW-1:0]         errorepc_o,
    output logic [AW-1:0]         depc_o,
    output logic [DBG_W-1:0]      debug_o,
    output logic                  dm_o
);

    localparam logic [AW-1:0] RET_STEP = AW'(4);

    typedef struct packed {
        logic                taken;
        logic [AW-1:0]       pc;
        logic [STAT_W-1:0]   status;
        logic [CAUSE_W-1:0]  cause;
        logic [AW-1:0]       epc;
        logic [AW-1:0]       errepc;
        logic [AW-1:0]       depc;
        logic [DBG_W-1:0]    dbg;
        logic                dm;
    } seq_state_t;

    seq_state_t st_d, st_q;

    exc_class_e           cls;
    logic [CODE_W-1:0]    code;
    logic [VEC_ALIGN-1:0] off;
    logic [DBG_W-1:0]     dmask;
    logic                 rewind, set_sr, set_nmi, cop;
    logic [AW-1:0]        target;
    logic [AW-1:0]        ret_addr;
    logic                 exl_in;

    assign exl_in = status_i[ST_EXL];

    exc_classify u_classify (
        .kind_i    (kind_i),
        .dm_i      (dm_i),
        .exl_i     (exl_in),
        .nomatch_i (tlb_nomatch_i),
        .iv_i      (cause_i[CA_IV]),
        .cls_o     (cls),
        .code_o    (code),
        .off_o     (off),
        .dmask_o   (dmask),
        .rewind_o  (rewind),
        .set_sr_o  (set_sr),
        .set_nmi_o (set_nmi),
        .cop_o     (cop)
    );

    exc_vector #(
        .AW        (AW),
        .BOOT_GEN  (BOOT_GEN),
        .RESET_VEC (RESET_VEC),
        .DEBUG_VEC (DEBUG_VEC)
    ) u_vector (
        .cls_i    (cls),
        .bev_i    (status_i[ST_BEV]),
        .ebase_i  (ebase_i),
        .off_i    (off),
        .target_o (target)
    );

    assign ret_addr = (delay_slot_i && rewind) ? (pc_i - RET_STEP) : pc_i;

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (take_i && cls != CLS_NONE) begin
            st_d.taken  = 1'b1;
            st_d.pc     = target;
            st_d.status = status_i;
            st_d.cause  = cause_i;
            st_d.epc    = epc_i;
            st_d.errepc = errorepc_i;
            st_d.depc   = depc_i;
            st_d.dbg    = debug_i;
            st_d.dm     = dm_i;
            st_d.status[ST_KSU +: 2] = 2'b00;
            case (cls)
                CLS_GEN: begin
                    if (!exl_in) begin
                        st_d.epc          = ret_addr;
                        st_d.cause[CA_BD] = delay_slot_i;
                    end
                    st_d.status[ST_EXL]       = 1'b1;
                    st_d.cause[CA_CODE +: CODE_W] = code;
                    if (cop) st_d.cause[CA_CE +: 2] = cop_unit_i;
                end
                CLS_ERR: begin
                    st_d.errepc         = ret_addr;
                    st_d.status[ST_ERL] = 1'b1;
                    st_d.status[ST_BEV] = 1'b1;
                    if (set_sr)  st_d.status[ST_SR]  = 1'b1;
                    if (set_nmi) st_d.status[ST_NMI] = 1'b1;
                    if (!exl_in) st_d.cause[CA_BD]   = 1'b0;
                end
                default: begin
                    st_d.depc = ret_addr;
                    st_d.dbg  = debug_i | dmask;
                    st_d.dm   = 1'b1;
                    if (!exl_in) st_d.cause[CA_BD] = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taken_o    = st_q.taken;
    assign pc_o       = st_q.pc;
    assign status_o   = st_q.status;
    assign cause_o    = st_q.cause;
    assign epc_o      = st_q.epc;
    assign errorepc_o = st_q.errepc;
    assign depc_o     = st_q.depc;
    assign debug_o    = st_q.dbg;
    assign dm_o       = st_q.dm;

    AST_GEN_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls == CLS_GEN |=> taken_o && status_o[ST_EXL] && status_o[ST_KSU +: 2] == 2'b00); // R2
    AST_GEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls == CLS_GEN |=> cause_o[CA_CODE +: CODE_W] == $past(code)); // R2
    AST_NESTED_EPC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls == CLS_GEN && status_i[ST_EXL]
        |=> epc_o == $past(epc_i) && cause_o[CA_BD] == $past(cause_i[CA_BD])); // R3
    AST_ERR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls == CLS_ERR |=> pc_o == RESET_VEC && status_o[ST_ERL] && status_o[ST_BEV]
        && epc_o == $past(epc_i)); // R8
    AST_DBG_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && cls == CLS_DBG |=> pc_o == DEBUG_VEC && dm_o && $countones(debug_o & ~$past(debug_i)) <= 1); // R9
    AST_DM_IRQ_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && kind_i == EX_INT && dm_i |=> pc_o == DEBUG_VEC && debug_o[1]); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_i && cls != CLS_NONE) |=> !taken_o && $stable(pc_o) && $stable(epc_o) && $stable(status_o)); // R11

endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take = 1'b0;
    logic [4:0]  kind = '0;
    logic [31:0] pc = '0;
    logic        ds = 1'b0;
    logic        nomatch = 1'b0;
    logic [1:0]  cop = '0;
    logic [21:0] ebase = '0;
    logic [7:0]  status = '0;
    logic [31:0] cause = '0;
    logic [31:0] epc = '0, errepc = '0, depc = '0;
    logic [5:0]  dbg = '0;
    logic        dm = 1'b0;

    logic        taken_o, dm_o;
    logic [31:0] pc_o, cause_o, epc_o, errorepc_o, depc_o;
    logic [7:0]  status_o;
    logic [5:0]  debug_o;

    logic        e_taken = 1'b0, e_dm = 1'b0;
    logic [31:0] e_pc = '0, e_cause = '0, e_epc = '0, e_errepc = '0, e_depc = '0;
    logic [7:0]  e_status = '0;
    logic [5:0]  e_dbg = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .take_i(take), .kind_i(kind), .pc_i(pc),
        .delay_slot_i(ds), .tlb_nomatch_i(nomatch), .cop_unit_i(cop), .ebase_i(ebase),
        .status_i(status), .cause_i(cause), .epc_i(epc), .errorepc_i(errepc),
        .depc_i(depc), .debug_i(dbg), .dm_i(dm),
        .taken_o(taken_o), .pc_o(pc_o), .status_o(status_o), .cause_o(cause_o),
        .epc_o(epc_o), .errorepc_o(errorepc_o), .depc_o(depc_o), .debug_o(debug_o),
        .dm_o(dm_o)
    );

    function automatic string tag_of(input logic [4:0] k, input logic d);
        if (k > 5'd19)                return "R11";
        if (k == 5'd0 && d)           return "R10";
        if (k == 5'd0)                return "R6";
        if (k == 5'd2 || k == 5'd3)   return "R5";
        if (k == 5'd9)                return "R7";
        if (k <= 5'd10)               return "R2";
        if (k <= 5'd13)               return "R8";
        return "R9";
    endfunction

    // Expected result, computed from the requirements
    task automatic model();
        logic [4:0]  k;
        logic [31:0] ret, base;
        logic [9:0]  offs;
        if (!take || kind > 5'd19) begin
            e_taken = 1'b0;
            return;
        end
        k = (kind == 5'd0 && dm) ? 5'd15 : kind;
        e_taken = 1'b1; e_status = status; e_cause = cause; e_epc = epc;
        e_errepc = errepc; e_depc = depc; e_dbg = dbg; e_dm = dm;
        ret = ds ? pc - 32'd4 : pc;
        e_status[6:5] = 2'b00;
        if (k <= 5'd10) begin
            offs = 10'h180;
            if (k == 5'd0 && cause[23]) offs = 10'h200;
            if ((k == 5'd2 || k == 5'd3) && nomatch && !status[0]) offs = 10'h000;
            base = status[2] ? 32'hBFC0_0200 : {ebase, 10'b0};
            e_pc = base + {22'b0, offs};
            if (!status[0]) begin e_epc = ret; e_cause[31] = ds; end
            e_status[0] = 1'b1;
            e_cause[6:2] = (k <= 5'd5) ? k : k + 5'd2;
            if (k == 5'd9) e_cause[29:28] = cop;
        end else if (k <= 5'd13) begin
            e_errepc = ret;
            e_status[1] = 1'b1; e_status[2] = 1'b1;
            if (k == 5'd12) e_status[3] = 1'b1;
            if (k == 5'd13) e_status[4] = 1'b1;
            if (!status[0]) e_cause[31] = 1'b0;
            e_pc = 32'hBFC0_0000;
        end else begin
            e_depc = (k == 5'd14) ? pc : ret;
            e_dbg[k - 5'd14] = 1'b1;
            e_dm = 1'b1;
            if (!status[0]) e_cause[31] = 1'b0;
            e_pc = 32'hBFC0_0480;
        end
    endtask

    task automatic check(input string tag);
        logic [198:0] got, exp;
        got = {taken_o, pc_o, status_o, cause_o, epc_o, errorepc_o, depc_o, debug_o, dm_o};
        exp = {e_taken, e_pc, e_status, e_cause, e_epc, e_errepc, e_depc, e_dbg, e_dm};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s kind=%0d: got tk=%b pc=%h st=%h ca=%h epc=%h err=%h dpc=%h dbg=%h dm=%b exp tk=%b pc=%h st=%h ca=%h epc=%h err=%h dpc=%h dbg=%h dm=%b",
                tag, kind, taken_o, pc_o, status_o, cause_o, epc_o, errorepc_o, depc_o, debug_o, dm_o,
                e_taken, e_pc, e_status, e_cause, e_epc, e_errepc, e_depc, e_dbg, e_dm);
        end
    endtask

    task automatic apply(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic setup(input logic t, input logic [4:0] k, input logic [31:0] p,
                         input logic d, input logic [7:0] s, input logic [31:0] c);
        take = t; kind = k; pc = p; ds = d; status = s; cause = c;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1");                              // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");                              // R1 after release

        epc = 32'h1111_0000; errepc = 32'h2222_0000; depc = 32'h3333_0000;
        ebase = 22'h20_0001; dbg = 6'b0;
        // R3: delay slot, level clear, boot vectors -> general vector
        setup(1, 5'd4, 32'h8000_1004, 1, 8'h64, 32'h0000_0000); apply("R3");
        // R3: nested, level already set
        setup(1, 5'd6, 32'h8000_2004, 1, 8'h01, 32'h8000_0000); apply("R3");
        // R4: programmed base
        setup(1, 5'd10, 32'h8000_3000, 0, 8'h00, 32'hFFFF_FFFF); apply("R4");
        // R5: refill, miss with level clear
        nomatch = 1;
        setup(1, 5'd2, 32'h0040_0000, 0, 8'h04, 32'h0); apply("R5");
        setup(1, 5'd3, 32'h0040_0010, 0, 8'h05, 32'h0); apply("R5");
        nomatch = 0;
        setup(1, 5'd3, 32'h0040_0020, 0, 8'h00, 32'h0); apply("R5");
        // R6: interrupt with vector-select bit
        setup(1, 5'd0, 32'h0040_0100, 0, 8'h00, 32'h0080_0000); apply("R6");
        setup(1, 5'd0, 32'h0040_0100, 0, 8'h04, 32'h0080_0000); apply("R6");
        // R7
        cop = 2'd3;
        setup(1, 5'd9, 32'h0040_0200, 1, 8'h00, 32'h0); apply("R7");
        // R8
        setup(1, 5'd11, 32'h0040_0300, 1, 8'h00, 32'h8000_0000); apply("R8");
        setup(1, 5'd12, 32'h0040_0304, 1, 8'h60, 32'h8000_0000); apply("R8");
        setup(1, 5'd13, 32'h0040_0308, 0, 8'h01, 32'h8000_0000); apply("R8");
        // R9: single-step in delay slot does not rewind; breakpoint does
        setup(1, 5'd14, 32'h0040_0400, 1, 8'h00, 32'h0); apply("R9");
        setup(1, 5'd17, 32'h0040_0404, 1, 8'h01, 32'h8000_0000); apply("R9");
        // R10
        dm = 1;
        setup(1, 5'd0, 32'h0040_0500, 1, 8'h00, 32'h0); apply("R10");
        dm = 0;
        // R11: invalid kind and no strobe hold the outputs
        setup(1, 5'd21, 32'h0040_0600, 0, 8'h00, 32'h0); apply("R11");
        setup(0, 5'd1, 32'h0040_0700, 0, 8'h00, 32'h0); apply("R11");

        for (int i = 0; i < 600; i++) begin
            take    = ($urandom_range(0, 7) != 0);
            kind    = 5'($urandom_range(0, 21));
            pc      = $urandom;
            ds      = 1'($urandom);
            nomatch = 1'($urandom);
            cop     = 2'($urandom);
            ebase   = 22'($urandom);
            status  = 8'($urandom);
            cause   = $urandom;
            epc     = $urandom;
            errepc  = $urandom;
            depc    = $urandom;
            dbg     = 6'($urandom);
            dm      = ($urandom_range(0, 3) == 0);
            apply(take ? tag_of(kind, dm) : "R11");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule